// File: doc/BRIEF.md
# Tap-Selectable Fibonacci LFSR

This block is a linear feedback shift register built from D flip-flops. It has a fixed width, eight bits by default. The register shifts one place toward its least significant end on every enabled clock. The bit shifted into the most significant stage is the XOR of the least significant stage and those upper stages that an elaboration-time tap mask selects. The mask holds one bit for each stage above the bottom one. The bottom stage always takes part in the feedback and has no gate of its own.

A synchronous reset loads the register from a seed input, so each instance can start anywhere in its sequence. A small decoder turns the reset and enable inputs into one of three named operations. LOAD is the reset operation, SHIFT is an enabled step, and HOLD means nothing happens. A unique case on that operation drives the state register. The 8-bit state is visible at the output every cycle.

Top module: `tapped_shift_lfsr`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `state_o` equals `seed_i` after that edge, whatever `step_en` is (operation LOAD).
- R2: When `rst` is 0 and `step_en` is 1 at an edge (operation SHIFT), each bit `state_o[i]` for i from 0 to 6 takes the old value of `state_o[i+1]`.
- R3: In a SHIFT, the new `state_o[7]` is the old `state_o[0]` XORed with every old `state_o[k+1]` whose tap mask bit `TAP_SEL[k]` is 1, for k from 0 to 6. A mask bit of 0 leaves that stage out.
- R4: When `rst` and `step_en` are both 0 at an edge (operation HOLD), `state_o` keeps its value.
- R5: A register holding all zeros stays at all zeros under SHIFT, whatever the mask.
- R6: With the default mask 7'b0001110 (polynomial x^8+x^4+x^3+x^2+1) and a nonzero seed, the state first returns to the seed after exactly 255 SHIFT steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the seed |
| step_en | input | 1 | Advance the register by one step |
| seed_i | input | 8 | Value loaded on reset |
| state_o | output | 8 | Current register contents |

## Verification
Every operation is due one clock after the edge at which the bench presents its inputs, because the state register is the only storage between the inputs and `state_o`. The bench applies its inputs 1 ns after a rising edge. It works out the expected next state with its own step function, and it compares that value 1 ns after the following edge. Random reset, enable and seed patterns are mixed with directed cases for hold, the zero state and the full 255-step period. The same checks also run on a second instance that uses a different tap mask.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } lfsr_op_e;

endpackage

// File: rtl/lfsr_op_decode.sv
module lfsr_op_decode
    import lfsr_pkg::*;
(
    input  logic     rst,
    input  logic     step_en,
    output lfsr_op_e op
);
    always_comb begin
        if (rst)
            op = OP_LOAD;
        else if (step_en)
            op = OP_SHIFT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
    parameter int                 WIDTH   = 8,
    parameter logic [WIDTH-2:0]   TAP_SEL = 7'b0001110
) (
    input  logic [WIDTH-1:0] q,
    output logic             fb
);
    logic [WIDTH-1:0] chain;

    // the bottom stage enters the chain directly
    assign chain[0] = q[0];

    genvar gi;
    generate
        for (gi = 1; gi < WIDTH; gi++) begin : g_tap
            if (TAP_SEL[gi-1]) begin : g_on
                assign chain[gi] = chain[gi-1] ^ q[gi];
            end else begin : g_off
                assign chain[gi] = chain[gi-1];
            end
        end
    endgenerate

    assign fb = chain[WIDTH-1];
endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg
    import lfsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  lfsr_op_e         op,
    input  logic [WIDTH-1:0] seed,
    input  logic             fb,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_next;

    always_comb begin
        unique case (op)
            OP_LOAD:  q_next = seed;
            OP_SHIFT: q_next = {fb, q[WIDTH-1:1]};
            OP_HOLD:  q_next = q;
            default:  q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        q <= q_next;
    end
endmodule

// File: rtl/tapped_shift_lfsr.sv
module tapped_shift_lfsr
    import lfsr_pkg::*;
#(
    parameter int                 WIDTH   = 8,
    parameter logic [WIDTH-2:0]   TAP_SEL = 7'b0001110
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] state_o
);
    lfsr_op_e op;
    logic     fb;

    lfsr_op_decode u_dec (
        .rst     (rst),
        .step_en (step_en),
        .op      (op)
    );

    lfsr_feedback #(.WIDTH(WIDTH), .TAP_SEL(TAP_SEL)) u_fb (
        .q  (state_o),
        .fb (fb)
    );

    lfsr_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk  (clk),
        .op   (op),
        .seed (seed_i),
        .fb   (fb),
        .q    (state_o)
    );
endmodule

// File: rtl/lfsr_checker.sv
module lfsr_checker #(
    parameter int                 WIDTH   = 8,
    parameter logic [WIDTH-2:0]   TAP_SEL = 7'b0001110
) (
    input logic             clk,
    input logic             rst,
    input logic             step_en,
    input logic [WIDTH-1:0] seed_i,
    input logic [WIDTH-1:0] state_o
);
    localparam logic [WIDTH-1:0] FULL_MASK = {TAP_SEL, 1'b1};

    logic             armed  = 1'b0;
    logic             rst_q  = 1'b0;
    logic [WIDTH-1:0] seed_q = '0;

    always @(posedge clk) begin
        if (rst) armed <= 1'b1;
        rst_q  <= rst;
        seed_q <= seed_i;
    end

    always @(posedge clk) begin
        if (rst_q)
            AST_SEED_LOAD: assert (state_o == seed_q); // R1
    end

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst || !armed)
        step_en |=> state_o[WIDTH-2:0] == $past(state_o[WIDTH-1:1])); // R2

    AST_FEEDBACK_BIT: assert property (@(posedge clk) disable iff (rst || !armed)
        step_en |=> state_o[WIDTH-1] == ^($past(state_o) & FULL_MASK)); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst || !armed)
        !step_en |=> $stable(state_o)); // R4

    AST_ZERO_LOCK: assert property (@(posedge clk) disable iff (rst || !armed)
        (step_en && state_o == '0) |=> state_o == '0); // R5
endmodule

bind tapped_shift_lfsr lfsr_checker #(.WIDTH(WIDTH), .TAP_SEL(TAP_SEL)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .seed_i  (seed_i),
    .state_o (state_o)
);

// File: tb/tapped_shift_lfsr_tb.sv
`timescale 1ns/100ps
module tapped_shift_lfsr_tb;
    localparam logic [6:0] TAPS_A = 7'b0001110;
    localparam logic [6:0] TAPS_B = 7'b1000000;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       step_en = 1'b0;
    logic [7:0] seed_i = 8'h00;
    logic [7:0] state_a, state_b;
    logic [7:0] exp_a, exp_b;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tapped_shift_lfsr #(.WIDTH(8), .TAP_SEL(TAPS_A)) u_dut (
        .clk(clk), .rst(rst), .step_en(step_en), .seed_i(seed_i), .state_o(state_a));

    tapped_shift_lfsr #(.WIDTH(8), .TAP_SEL(TAPS_B)) u_alt (
        .clk(clk), .rst(rst), .step_en(step_en), .seed_i(seed_i), .state_o(state_b));

    // R2/R3 model: shift right, new top bit from bottom bit plus selected stages
    function automatic logic [7:0] model_step(input logic [7:0] s, input logic [6:0] taps);
        logic f;
        f = s[0];
        for (int k = 0; k < 7; k++) if (taps[k]) f = f ^ s[k+1];
        return {f, s[7:1]};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic r, input logic e, input logic [7:0] s, input string tag);
        rst = r; step_en = e; seed_i = s;
        if (r) begin exp_a = s; exp_b = s; end
        else if (e) begin exp_a = model_step(exp_a, TAPS_A); exp_b = model_step(exp_b, TAPS_B); end
        @(posedge clk); #1;
        check(tag, state_a, exp_a);
        check({tag, " alt"}, state_b, exp_b);
    endtask

    initial begin
        int unused;
        int steps;
        unused = $urandom(32'h1F2E3D4C);
        @(posedge clk); #1;

        // R1: reset loads seed, reset wins over enable
        tick(1'b1, 1'b1, 8'hA5, "R1 reset load");
        tick(1'b1, 1'b0, 8'h3C, "R1 reseed");

        // R4: hold
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 8'hFF, "R4 hold");

        // R2/R3: directed single-tap behaviour from one-hot states
        tick(1'b1, 1'b0, 8'h02, "R1 load 02");
        tick(1'b0, 1'b1, 8'h00, "R3 tap stage1 off");
        tick(1'b0, 1'b1, 8'h00, "R3 bottom feeds top");
        tick(1'b1, 1'b0, 8'h80, "R1 load 80");
        tick(1'b0, 1'b1, 8'h00, "R2 shift right");

        // R5: zero lockup
        tick(1'b1, 1'b0, 8'h00, "R1 load zero");
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 8'h00, "R5 zero stays");

        // R6: period of the default mask
        tick(1'b1, 1'b0, 8'h01, "R1 load 01");
        steps = 0;
        rst = 1'b0; step_en = 1'b1;
        do begin
            @(posedge clk); #1;
            steps++;
        end while (state_a != 8'h01 && steps < 300);
        checks++;
        if (steps != 255) begin
            errors++;
            $display("FAIL R6 period: actual %0d expected %0d", steps, 255);
        end

        // random mix: R1 R2 R3 R4
        tick(1'b1, 1'b0, 8'h5A, "R1 load 5A");
        for (int i = 0; i < 400; i++) begin
            logic r, e;
            logic [7:0] s;
            r = ($urandom % 16) == 0;
            e = ($urandom % 4) != 0;
            s = 8'($urandom);
            if (r && s == 8'h00) s = 8'h11;
            tick(r, e, s, "R2 R3 R4 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule